// File: doc/BRIEF.md
# Banked Data Address Generator

This unit converts the 8-bit file-register operand of a byte- or bit-oriented instruction into a 12-bit data-memory address. It uses three inputs to pick the address. The first is the operand's access-select bit. The second is a 4-bit bank register. The third is a 12-bit pointer register that is used as a base for indexed accesses. A configuration input turns on the extended mode. In that mode, low operands with the access bit clear stop naming fixed locations. Each one becomes an offset that is added to the pointer.

The bank and pointer registers are held inside the unit. Write strobes load them, and their current values are always present on readback ports. An address request is registered. The address and a valid flag appear one cycle after the request. The extended-mode input is captured once after reset. Changes to it after that are ignored until the next reset. The reset is asynchronous active-low, and the unit releases it synchronously two clock edges after the pin rises.

Top module: `banked_addr_gen`

## Requirements
- R1: While reset is held and directly after it, `addr` is 0x000, `addr_vld` is 0, `bank_q` is 0x0 and `ptr_q` is 0x000.
- R2: With `acc_bit`=1, the address is {bank register[3:0], operand[7:0]}, whatever the mode.
- R3: With extended mode off and `acc_bit`=0, operands 0x00–0x5F map to 0x000–0x05F and operands 0x60–0xFF map to 0xF60–0xFFF.
- R4: With extended mode on, `acc_bit`=0 and an operand of 0x5F or less, the address is (pointer + zero-extended operand) modulo 4096.
- R5: With extended mode on, `acc_bit`=0 and an operand of 0x60 or more, the address uses the R3 mapping, 0xF00 | operand.
- R6: In extended mode, when the pointer is zero, indexed operands 0x00–0x5F give the same addresses that R3 gives.
- R7: A write strobe loads its register on the clock edge. The new value is on its readback port from the next cycle and affects addresses from the next request onward. A request in the same cycle as a write uses the old value.
- R8: `ext_en` is captured on the first clock after the internal reset releases. Later changes to it have no effect on address generation until the next reset.
- R9: `addr_vld` is `req` delayed by one cycle. `addr` is updated only for a request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Extended-mode configuration, captured after reset |
| req | input | 1 | Address request strobe |
| acc_bit | input | 1 | Access-select bit of the operand: 1 = banked, 0 = access/indexed |
| fld | input | 8 | File-register operand field |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 4 | Bank register write value |
| ptr_we | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 12 | Pointer register write value |
| bank_q | output | 4 | Bank register readback |
| ptr_q | output | 12 | Pointer register readback |
| addr | output | 12 | Generated data address, registered |
| addr_vld | output | 1 | Address valid, one cycle after `req` |

## Verification
A register write and an address request that reads the same register can occur in the same cycle. The bench makes this happen by driving random write strobes together with random requests. It also runs directed cases where the pointer or bank is rewritten in the same cycle as an indexed or banked request. Each such address is checked against a bench model that uses the register value from before the write. The following request is checked against the new value.

// File: rtl/bdag_pkg.sv
package bdag_pkg;
  localparam int FLD_W  = 8;
  localparam int BANK_W = 4;
  localparam int ADDR_W = BANK_W + FLD_W;
  localparam logic [FLD_W-1:0] LOW_SPLIT = 8'h60;

  typedef enum logic [1:0] {
    SRC_BANKED  = 2'd0,
    SRC_ACC_LOW = 2'd1,
    SRC_ACC_HI  = 2'd2,
    SRC_INDEXED = 2'd3
  } addr_src_e;
endpackage

// File: rtl/bdag_rst_sync.sv
module bdag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bdag_sel_regs.sv
module bdag_sel_regs
  import bdag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              ptr_we,
  input  logic [ADDR_W-1:0] ptr_wdata,
  output logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              ext_mode
);
  logic [BANK_W-1:0] bank_d;
  logic [ADDR_W-1:0] ptr_d;
  logic              cfg_done_q, cfg_done_d;
  logic              ext_q, ext_d;

  always_comb begin
    bank_d     = bank_q;
    ptr_d      = ptr_q;
    ext_d      = ext_q;
    cfg_done_d = 1'b1;
    if (bank_we)     bank_d = bank_wdata;
    if (ptr_we)      ptr_d  = ptr_wdata;
    if (!cfg_done_q) ext_d  = ext_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q     <= '0;
      ptr_q      <= '0;
      ext_q      <= 1'b0;
      cfg_done_q <= 1'b0;
    end else begin
      bank_q     <= bank_d;
      ptr_q      <= ptr_d;
      ext_q      <= ext_d;
      cfg_done_q <= cfg_done_d;
    end
  end

  assign ext_mode = cfg_done_q ? ext_q : ext_en;

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> ptr_q == $past(ptr_wdata)); // R7
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> bank_q == $past(bank_wdata)); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done_q |=> $stable(ext_mode)); // R8
endmodule

// File: rtl/bdag_map.sv
module bdag_map
  import bdag_pkg::*;
(
  input  logic              ext_mode,
  input  logic              acc_bit,
  input  logic [FLD_W-1:0]  fld,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] addr_raw
);
  addr_src_e src;
  logic      low;

  assign low = (fld < LOW_SPLIT);

  always_comb begin
    if (acc_bit)              src = SRC_BANKED;
    else if (low && ext_mode) src = SRC_INDEXED;
    else if (low)             src = SRC_ACC_LOW;
    else                      src = SRC_ACC_HI;
  end

  always_comb begin
    unique case (src)
      SRC_BANKED:  addr_raw = {bank, fld};
      SRC_ACC_LOW: addr_raw = {{BANK_W{1'b0}}, fld};
      SRC_ACC_HI:  addr_raw = {{BANK_W{1'b1}}, fld};
      SRC_INDEXED: addr_raw = ptr + {{BANK_W{1'b0}}, fld};
      default:     addr_raw = '0;
    endcase
  end
endmodule

// File: rtl/bdag_out_stage.sv
module bdag_out_stage
  import bdag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr_raw,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_vld
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (req) addr_d = addr_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr     <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr     <= addr_d;
      addr_vld <= req;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(addr)); // R9
endmodule

// File: rtl/banked_addr_gen.sv
module banked_addr_gen
  import bdag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_en,
  input  logic        req,
  input  logic        acc_bit,
  input  logic [7:0]  fld,
  input  logic        bank_we,
  input  logic [3:0]  bank_wdata,
  input  logic        ptr_we,
  input  logic [11:0] ptr_wdata,
  output logic [3:0]  bank_q,
  output logic [11:0] ptr_q,
  output logic [11:0] addr,
  output logic        addr_vld
);
  logic              rst_sync_n;
  logic              ext_mode;
  logic [ADDR_W-1:0] addr_raw;

  bdag_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bdag_sel_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ext_en     (ext_en),
    .bank_we    (bank_we),
    .bank_wdata (bank_wdata),
    .ptr_we     (ptr_we),
    .ptr_wdata  (ptr_wdata),
    .bank_q     (bank_q),
    .ptr_q      (ptr_q),
    .ext_mode   (ext_mode)
  );

  bdag_map u_map (
    .ext_mode (ext_mode),
    .acc_bit  (acc_bit),
    .fld      (fld),
    .bank     (bank_q),
    .ptr      (ptr_q),
    .addr_raw (addr_raw)
  );

  bdag_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (req),
    .addr_raw (addr_raw),
    .addr     (addr),
    .addr_vld (addr_vld)
  );

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req |=> addr_vld); // R9
  AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req |=> !addr_vld); // R9
  AST_BANKED_FORM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req && acc_bit) |=> (addr == {$past(bank_q), $past(fld)})); // R2
  AST_ACC_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req && !acc_bit && fld >= LOW_SPLIT) |=> (addr == {4'hF, $past(fld)})); // R5
endmodule

// File: tb/banked_addr_gen_test.sv
`timescale 1ns/1ps
module banked_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_en, req, acc_bit, bank_we, ptr_we;
  logic [7:0]  fld;
  logic [3:0]  bank_wdata;
  logic [11:0] ptr_wdata;
  logic [3:0]  bank_q;
  logic [11:0] ptr_q, addr;
  logic        addr_vld;

  int n_chk = 0;
  int n_bad = 0;
  logic        m_ext;
  logic [3:0]  m_bank;
  logic [11:0] m_ptr, m_addr;

  always #2.5 clk = ~clk;

  banked_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .req(req), .acc_bit(acc_bit),
    .fld(fld), .bank_we(bank_we), .bank_wdata(bank_wdata), .ptr_we(ptr_we),
    .ptr_wdata(ptr_wdata), .bank_q(bank_q), .ptr_q(ptr_q), .addr(addr),
    .addr_vld(addr_vld)
  );

  function automatic logic [11:0] exp_addr(logic ext, logic a, logic [7:0] f,
                                           logic [3:0] b, logic [11:0] p);
    if (a)              return {b, f};
    if (ext && f < 8'h60) return p + {4'h0, f};
    if (f < 8'h60)      return {4'h0, f};
    return {4'hF, f};
  endfunction

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req = 0; acc_bit = 0; fld = 0; bank_we = 0; bank_wdata = 0;
    ptr_we = 0; ptr_wdata = 0;
  endtask

  task automatic do_reset(logic ext);
    @(negedge clk);
    idle_inputs();
    ext_en = ext;
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 addr", {20'h0, addr}, 32'h0);
    chk("R1 vld", {31'h0, addr_vld}, 32'h0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 bank", {28'h0, bank_q}, 32'h0);
    chk("R1 ptr", {20'h0, ptr_q}, 32'h0);
    m_ext = ext; m_bank = 0; m_ptr = 0; m_addr = 0;
  endtask

  // One cycle: inputs are set at negedge, results checked at next negedge.
  task automatic step(string tag, logic r, logic a, logic [7:0] f,
                      logic bw, logic [3:0] bd, logic pw, logic [11:0] pd);
    logic [11:0] e;
    req = r; acc_bit = a; fld = f;
    bank_we = bw; bank_wdata = bd; ptr_we = pw; ptr_wdata = pd;
    e = exp_addr(m_ext, a, f, m_bank, m_ptr);
    @(posedge clk);
    if (r) m_addr = e;
    if (bw) m_bank = bd;
    if (pw) m_ptr = pd;
    @(negedge clk);
    chk({tag, " addr"}, {20'h0, addr}, {20'h0, m_addr});
    chk("R9 vld", {31'h0, addr_vld}, {31'h0, r});
    chk("R7 bank", {28'h0, bank_q}, {28'h0, m_bank});
    chk("R7 ptr", {20'h0, ptr_q}, {20'h0, m_ptr});
    idle_inputs();
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] v;
      v = $urandom;
      step(v[1] ? "R2" : (m_ext ? "R4" : "R3"), v[0], v[1], 8'($urandom),
           (v[7:4] == 0), 4'($urandom), (v[11:8] == 0), 12'($urandom));
    end
  endtask

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    idle_inputs();
    ext_en = 0;
    rst_n = 0;

    // Non-extended mode
    do_reset(1'b0);
    step("R3", 1, 0, 8'h00, 0, 0, 0, 0);
    step("R3", 1, 0, 8'h5F, 0, 0, 0, 0);
    step("R3", 1, 0, 8'h60, 0, 0, 0, 0);
    step("R3", 1, 0, 8'hFF, 0, 0, 0, 0);
    step("R7", 0, 0, 8'h00, 1, 4'hA, 1, 12'h321);
    step("R2", 1, 1, 8'h12, 0, 0, 0, 0);
    step("R3", 1, 0, 8'h10, 0, 0, 0, 0);   // pointer ignored when mode off
    step("R9", 0, 1, 8'h77, 0, 0, 0, 0);   // no request: addr holds
    rand_run(2000);

    // Extended mode
    do_reset(1'b1);
    step("R6", 1, 0, 8'h00, 0, 0, 0, 0);
    step("R6", 1, 0, 8'h5F, 0, 0, 0, 0);
    step("R7", 0, 0, 8'h00, 0, 0, 1, 12'hFC0);
    step("R4", 1, 0, 8'h5F, 0, 0, 0, 0);   // wraps to 0x01F
    step("R5", 1, 0, 8'h60, 0, 0, 0, 0);
    step("R5", 1, 0, 8'hC3, 0, 0, 0, 0);
    step("R7", 1, 0, 8'h04, 0, 0, 1, 12'h100); // same-cycle write: old pointer
    step("R7", 1, 0, 8'h04, 0, 0, 0, 0);       // new pointer now
    step("R7", 1, 1, 8'h33, 1, 4'h5, 0, 0);    // same-cycle bank write
    step("R2", 1, 1, 8'h33, 0, 0, 0, 0);
    ext_en = 0;                                // late change ignored
    step("R8", 1, 0, 8'h20, 0, 0, 0, 0);
    rand_run(2000);
    ext_en = 1;
    rand_run(200);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule